// File: doc/BRIEF.md
# RAID Parity Stripe Engine

This engine handles single-parity protection for a striped disk array, one word position of a stripe at a time. Each input beat carries the word at one position of every strip in the stripe, plus a small control header: the operation, the stripe number and, for recovery, the index of the lost drive. The engine can compute parity and lay the stripe out across the drives, either with one drive reserved for parity or with the parity slot rotating from stripe to stripe. It can also recover the word of a known failed drive from the survivors, or fold a small write into an existing parity word without touching the rest of the stripe.

Input and output are valid/ready streams with a single register stage between them. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in that same cycle. An output beat is held unchanged for as long as `out_valid` is high and `out_ready` is low. Because there is only one stage, output beats leave in the order the input beats arrived, so the word order of every strip is preserved.

Top module: `raid_stripe_engine`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: In both generate operations (op 0 and op 1), `out_word` is the bitwise XOR of the N-1 data words taken from slots 0..N-2 of `in_data`, where slot i occupies bits i*W+W-1 down to i*W.
- R3: With op 0 (fixed parity), `out_pidx` is N-1, data word k goes to output slot k for k < N-1, and the parity word goes to slot N-1.
- R4: With op 1 (rotating parity), `out_pidx` is (N-1) - (stripe mod N). The parity word goes to that slot, and the data words fill the other slots in ascending order.
- R5: With op 2 (rebuild), `in_data` holds the stripe as laid out on the drives. `out_word` is the XOR of every slot except slot `in_fail`, and the content of that slot has no effect. `out_data` is the input with slot `in_fail` replaced by `out_word`, and `out_pidx` equals `in_fail`.
- R6: With op 3 (small update), slot 0 holds the old parity, slot 1 the old data and slot 2 the new data. `out_word` is the XOR of those three words, `out_data` is the input with slot 0 replaced by `out_word`, and `out_pidx` is 0.
- R7: The result of an accepted beat appears on the outputs one cycle after the accepting edge. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R8: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values.
- R9: Output beats leave in acceptance order, and `out_last` repeats the `in_last` of the same beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Engine can take a beat |
| in_op | input | 2 | 0 fixed-parity generate, 1 rotating generate, 2 rebuild, 3 small update |
| in_stripe | input | 16 | Stripe number, used by op 1 |
| in_fail | input | 2 | Failed drive index, used by op 2 |
| in_data | input | 64 | One word per slot, N=4 slots of W=16 bits |
| in_last | input | 1 | Last word of the strips |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 64 | Placed, repaired or updated stripe words |
| out_word | output | 16 | Parity, rebuilt or new-parity word |
| out_pidx | output | 2 | Slot holding `out_word` |
| out_last | output | 1 | Copy of `in_last` |

## Verification
Every result is due exactly one edge after the beat is taken. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, after the accepting rising edge. A stall sequence holds `out_ready` low for three edges with a second beat waiting. It checks that `in_ready` stays low and that the first beat does not change. Once `out_ready` rises, the first beat leaves and the second is taken on the same edge, and the second beat is checked one falling edge later. The sweeps cover rotation over twelve consecutive stripes and rebuild of every drive in turn.

// File: rtl/raid_pkg.sv
package raid_pkg;
  typedef enum logic [1:0] {
    OP_GEN_FIXED = 2'd0,
    OP_GEN_ROT   = 2'd1,
    OP_REBUILD   = 2'd2,
    OP_UPDATE    = 2'd3
  } raid_op_e;
endpackage

// File: rtl/raid_xor_reduce.sv
// Masked XOR across NW words of W bits.
module raid_xor_reduce #(
  parameter int NW = 4,
  parameter int W  = 16
) (
  input  logic [NW*W-1:0] words,
  input  logic [NW-1:0]   keep,
  output logic [W-1:0]    sum
);
  always_comb begin
    sum = '0;
    for (int i = 0; i < NW; i++) begin
      if (keep[i]) sum = sum ^ words[i*W +: W];
    end
  end
endmodule

// File: rtl/raid_parity_place.sv
// Computes parity of the data words and places data and parity onto drive slots.
module raid_parity_place #(
  parameter int N  = 4,
  parameter int W  = 16,
  parameter int SW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int ND = N - 1
) (
  input  logic            rotate,
  input  logic [SW-1:0]   stripe,
  input  logic [ND*W-1:0] data,
  output logic [W-1:0]    parity,
  output logic [IW-1:0]   pidx,
  output logic [N*W-1:0]  placed
);
  logic [SW-1:0] rem;

  raid_xor_reduce #(.NW(ND), .W(W)) u_par (
    .words (data),
    .keep  ({ND{1'b1}}),
    .sum   (parity)
  );

  always_comb begin
    rem  = stripe % SW'(N);
    pidx = rotate ? (IW'(N - 1) - IW'(rem)) : IW'(N - 1);
  end

  for (genvar j = 0; j < N; j++) begin : g_slot
    if (j == 0) begin : g_first
      assign placed[j*W +: W] = (pidx == IW'(j)) ? parity : data[0 +: W];
    end else if (j == N - 1) begin : g_lastslot
      assign placed[j*W +: W] = (pidx == IW'(j)) ? parity : data[(ND-1)*W +: W];
    end else begin : g_mid
      assign placed[j*W +: W] = (pidx == IW'(j)) ? parity :
                                (IW'(j) < pidx)  ? data[j*W +: W] :
                                                   data[(j-1)*W +: W];
    end
  end
endmodule

// File: rtl/raid_out_slice.sv
// Single register stage with full-throughput valid/ready.
module raid_out_slice #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_payload,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_payload
);
  logic          vld_q;
  logic [PW-1:0] pl_q;

  assign in_ready    = !vld_q || out_ready;
  assign out_valid   = vld_q;
  assign out_payload = pl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pl_q  <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) pl_q <= in_payload;
    end
  end

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: rtl/raid_stripe_engine.sv
module raid_stripe_engine #(
  parameter int N  = 4,
  parameter int W  = 16,
  parameter int SW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int ND = N - 1,
  localparam int PW = 2 + 1 + IW + W + N*W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [SW-1:0] in_stripe,
  input  logic [IW-1:0] in_fail,
  input  logic [N*W-1:0] in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [N*W-1:0] out_data,
  output logic [W-1:0]  out_word,
  output logic [IW-1:0] out_pidx,
  output logic          out_last
);
  import raid_pkg::*;

  raid_op_e      op;
  logic [W-1:0]  gen_par;
  logic [IW-1:0] gen_pidx;
  logic [N*W-1:0] gen_placed;
  logic [N-1:0]  fold_keep;
  logic [W-1:0]  fold_sum;
  logic [N*W-1:0] res_data;
  logic [W-1:0]  res_word;
  logic [IW-1:0] res_pidx;
  logic [PW-1:0] in_pl, out_pl;
  logic [1:0]    out_op;

  assign op = raid_op_e'(in_op);

  raid_parity_place #(.N(N), .W(W), .SW(SW)) u_place (
    .rotate (op == OP_GEN_ROT),
    .stripe (in_stripe),
    .data   (in_data[ND*W-1:0]),
    .parity (gen_par),
    .pidx   (gen_pidx),
    .placed (gen_placed)
  );

  // Rebuild drops the failed slot; small update folds slots 0..2.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (op == OP_REBUILD) fold_keep[i] = (IW'(i) != in_fail);
      else                  fold_keep[i] = (i < 3);
    end
  end

  raid_xor_reduce #(.NW(N), .W(W)) u_fold (
    .words (in_data),
    .keep  (fold_keep),
    .sum   (fold_sum)
  );

  always_comb begin
    res_data = in_data;
    res_word = fold_sum;
    res_pidx = '0;
    case (op)
      OP_GEN_FIXED, OP_GEN_ROT: begin
        res_data = gen_placed;
        res_word = gen_par;
        res_pidx = gen_pidx;
      end
      OP_REBUILD: begin
        for (int i = 0; i < N; i++) begin
          if (IW'(i) == in_fail) res_data[i*W +: W] = fold_sum;
        end
        res_pidx = in_fail;
      end
      default: begin
        res_data[0 +: W] = fold_sum;
        res_pidx = '0;
      end
    endcase
  end

  assign in_pl = {in_op, in_last, res_pidx, res_word, res_data};

  raid_out_slice #(.PW(PW)) u_slice (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_payload  (in_pl),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_payload (out_pl)
  );

  assign {out_op, out_last, out_pidx, out_word, out_data} = out_pl;

  // Checking logic: XOR over all output slots, and the word at out_pidx.
  logic [W-1:0] out_total;
  logic [W-1:0] out_at_pidx;
  always_comb begin
    out_total   = '0;
    out_at_pidx = '0;
    for (int i = 0; i < N; i++) begin
      out_total = out_total ^ out_data[i*W +: W];
      if (IW'(i) == out_pidx) out_at_pidx = out_data[i*W +: W];
    end
  end

  // R2
  stripe_xor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op != 2'd3) |-> (out_total == '0));

  // R5
  word_in_pidx_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_at_pidx == out_word));

  // R3
  fixed_pidx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == 2'd0) |-> (out_pidx == IW'(N - 1)));

  // R6
  update_pidx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == 2'd3) |-> (out_pidx == '0));
endmodule

// File: tb/raid_stripe_engine_tb.sv
`timescale 1ns/1ps
module raid_stripe_engine_tb;
  localparam int N = 4;
  localparam int W = 16;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_op = '0;
  logic [SW-1:0] in_stripe = '0;
  logic [1:0] in_fail = '0;
  logic [63:0] in_data = '0;
  logic in_last = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [63:0] out_data;
  logic [15:0] out_word;
  logic [1:0] out_pidx;
  logic out_last;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  raid_stripe_engine #(.N(N), .W(W), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_stripe(in_stripe), .in_fail(in_fail), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_word(out_word), .out_pidx(out_pidx), .out_last(out_last)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] rnd(input int a);
    int v;
    v = a * 40503 + 12345;
    v = v ^ (v >>> 7) ^ (a << 5);
    return v[15:0];
  endfunction

  // Expected layout: parity at p, data ascending in the other slots.
  function automatic logic [63:0] lay(input logic [47:0] d, input int p);
    logic [63:0] r;
    logic [15:0] par;
    int k;
    par = d[15:0] ^ d[31:16] ^ d[47:32];
    k = 0;
    r = '0;
    for (int j = 0; j < 4; j++) begin
      if (j == p) r[j*16 +: 16] = par;
      else begin
        r[j*16 +: 16] = d[k*16 +: 16];
        k++;
      end
    end
    return r;
  endfunction

  // Drive a beat and wait through the accepting edge; results are read after.
  task automatic send(input logic [1:0] op, input int s, input int f,
                      input logic [63:0] d, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_stripe = SW'(s); in_fail = 2'(f);
    in_data = d; in_last = last;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog got hang exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] d;
    logic [63:0] st;
    int p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 in_ready", {63'd0, in_ready}, 64'd1);

    // R3 fixed parity, R2 parity word
    for (int t = 0; t < 6; t++) begin
      d = {rnd(t*3+2), rnd(t*3+1), rnd(t*3)};
      send(2'd0, t * 5, 0, {16'hdead, d}, 1'b0);
      chk("R2 fixed parity", {48'd0, out_word}, {48'd0, d[15:0]^d[31:16]^d[47:32]});
      chk("R3 fixed layout", out_data, lay(d, 3));
      chk("R3 fixed pidx", {62'd0, out_pidx}, 64'd3);
      chk("R7 valid", {63'd0, out_valid}, 64'd1);
    end

    // R4 rotating over three full rotations
    for (int s = 0; s < 12; s++) begin
      d = {rnd(100+s), rnd(200+s), rnd(300+s)};
      p = 3 - (s % 4);
      send(2'd1, s, 0, {16'h0000, d}, 1'b0);
      chk("R4 rot pidx", {62'd0, out_pidx}, 64'(p));
      chk("R4 rot layout", out_data, lay(d, p));
      chk("R2 rot parity", {48'd0, out_word}, {48'd0, d[15:0]^d[31:16]^d[47:32]});
    end

    // R5 rebuild each drive in turn, failed slot filled with junk
    for (int s = 0; s < 8; s++) begin
      d = {rnd(500+s), rnd(600+s), rnd(700+s)};
      st = lay(d, 3 - (s % 4));
      for (int f = 0; f < 4; f++) begin
        logic [63:0] bad;
        bad = st;
        bad[f*16 +: 16] = rnd(900 + s*4 + f);
        send(2'd2, s, f, bad, 1'b0);
        chk("R5 rebuilt word", {48'd0, out_word}, {48'd0, st[f*16 +: 16]});
        chk("R5 repaired stripe", out_data, st);
        chk("R5 pidx", {62'd0, out_pidx}, 64'(f));
      end
    end

    // R6 small update
    for (int t = 0; t < 6; t++) begin
      logic [15:0] op_, od, nd;
      op_ = rnd(1000+t); od = rnd(1100+t); nd = rnd(1200+t);
      send(2'd3, 0, 0, {16'h5a5a, nd, od, op_}, 1'b0);
      chk("R6 new parity", {48'd0, out_word}, {48'd0, op_ ^ od ^ nd});
      chk("R6 data", out_data, {16'h5a5a, nd, od, op_ ^ od ^ nd});
      chk("R6 pidx", {62'd0, out_pidx}, 64'd0);
    end

    // R7 R8 R9 stall with a second beat waiting
    @(negedge clk);
    out_ready = 1'b0;
    d = {16'h1111, 16'h2222, 16'h3333};
    send(2'd0, 0, 0, {16'h0, d}, 1'b0);
    chk("R7 first valid", {63'd0, out_valid}, 64'd1);
    in_valid = 1'b1; in_op = 2'd0; in_data = {16'h0, 16'h4444, 16'h5555, 16'h6666};
    in_last = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R7 in_ready low", {63'd0, in_ready}, 64'd0);
      chk("R8 held data", out_data, lay(d, 3));
      chk("R8 held word", {48'd0, out_word}, {48'd0, 16'h1111^16'h2222^16'h3333});
      chk("R9 first last", {63'd0, out_last}, 64'd0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second beat", out_data, lay({16'h4444, 16'h5555, 16'h6666}, 3));
    chk("R9 second last", {63'd0, out_last}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R7 drained", {63'd0, out_valid}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule